// File: doc/BRIEF.md
# Parallel Issue Packet Rule Checker

This block inspects one issue packet of up to eight decoded operations for a machine whose datapath is split into two halves. Each half owns four execution units (logic L, shift S, multiply M, data/address D) and one register file: half 0 owns file A and half 1 owns file B. The block reports which slots break an issue rule before the packet is dispatched.

The checker is purely combinational. For every slot it receives a valid bit, the executing half, the unit class, a flag saying the operand comes from the opposite file, the memory access kind, the address base register, the load destination or store data register, and up to two source registers. It returns one violation bit per rule and, for each rule, a mask of the slots that caused it. Decode, execution and write-back timing belong to other blocks.

Top module: `issue_rule_chk`

## Requirements
- R1: Unit codes are L=0, S=1, M=2, D=3 and half is 0 or 1. When two or more valid slots name the same half and unit, `viol_o[0]` is set and `unit_mask_o` marks every such slot; otherwise both are clear.
- R2: For each half, if more than one valid slot on that half has the cross flag set on an L, S or M unit, `viol_o[1]` is set and `xpath_mask_o` marks all those slots on that half; a single user per half is legal.
- R3: A cross flag on a D-unit slot neither counts toward nor appears in the cross-path check.
- R4: Registers are five bits: bit 4 selects the file (0 = A, 1 = B), bits 3:0 the index. Access kind codes are none=0, load=1, store=2, 3 treated as none. A valid D-unit slot with a load or store whose base register file differs from its half sets `viol_o[2]` and its bit in `base_mask_o`.
- R5: If a valid load writes into file F and a valid store takes its data from the same file F, `viol_o[3]` is set and `ldst_mask_o` marks every valid load and store whose data register is in F.
- R6: Each valid source (slot valid and source valid) counts as one read. When more than four reads in the packet hit one register, `viol_o[4]` is set and `read_mask_o` marks each slot with a valid source naming that register.
- R7: Invalid slots contribute to no rule and never appear in any mask; an all-invalid packet gives all outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_vld_i | input | 8 | Slot holds an operation |
| slot_side_i | input | 8 | Executing half per slot |
| slot_unit_i | input | 16 | Unit class per slot, 2 bits each |
| slot_xpath_i | input | 8 | Operand taken from the opposite file |
| slot_ls_i | input | 16 | Memory access kind, 2 bits each |
| slot_base_i | input | 40 | Address base register, 5 bits each |
| slot_data_i | input | 40 | Load destination or store data register |
| src_vld_i | input | 16 | Source valid, slot s source k at bit 2s+k |
| src_reg_i | input | 80 | Source register, 5 bits each, same order |
| viol_o | output | 5 | Per-rule violation: unit, cross, base, load/store, reads |
| unit_mask_o | output | 8 | Slots sharing a unit |
| xpath_mask_o | output | 8 | Slots overusing a cross path |
| base_mask_o | output | 8 | D slots with a wrong-file base |
| ldst_mask_o | output | 8 | Loads and stores clashing on a file |
| read_mask_o | output | 8 | Slots reading an over-read register |

## Verification
Every result is combinational, so each output is due in the same cycle the packet is applied, with no register in the path. The bench changes the packet on the falling clock edge and compares all six outputs two nanoseconds later, well before the next rising edge, so no result depends on edge ordering. Sweeps cover all unit pairs, every half/unit/cross combination over three slots, all base and access combinations, read counts from zero to sixteen, and every valid pattern over a fully conflicting packet.

// File: rtl/issue_rule_pkg.sv
package issue_rule_pkg;
  typedef enum logic [1:0] {UNIT_L = 2'd0, UNIT_S = 2'd1, UNIT_M = 2'd2, UNIT_D = 2'd3} unit_e;
  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2, ACC_RSVD = 2'd3} acc_e;
  localparam int NUM_RULES = 5;
endpackage

// File: rtl/unit_clash.sv
module unit_clash #(
  parameter int NSLOT = 8
) (
  input  logic [NSLOT-1:0]   vld_i,
  input  logic [NSLOT-1:0]   side_i,
  input  logic [2*NSLOT-1:0] unit_i,
  output logic [NSLOT-1:0]   mask_o
);
  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NSLOT; i++)
      for (int j = 0; j < NSLOT; j++)
        if (i != j && vld_i[i] && vld_i[j] && side_i[i] == side_i[j] &&
            unit_i[2*i +: 2] == unit_i[2*j +: 2])
          mask_o[i] = 1'b1;
  end

  // a clash always involves at least two slots
  always_comb begin
    AST_UNIT_PAIR: assert ($countones(mask_o) != 1) else $error("lone unit clash"); // R1
  end
endmodule

// File: rtl/cross_limit.sv
module cross_limit
  import issue_rule_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic [NSLOT-1:0]   vld_i,
  input  logic [NSLOT-1:0]   side_i,
  input  logic [2*NSLOT-1:0] unit_i,
  input  logic [NSLOT-1:0]   xpath_i,
  output logic [NSLOT-1:0]   mask_o
);
  localparam int CNT_W = $clog2(NSLOT + 1);

  logic [NSLOT-1:0] use_x;
  logic [CNT_W-1:0] cnt [2];

  always_comb begin
    cnt[0] = '0;
    cnt[1] = '0;
    for (int i = 0; i < NSLOT; i++) begin
      use_x[i] = vld_i[i] && xpath_i[i] && (unit_e'(unit_i[2*i +: 2]) != UNIT_D);
      if (use_x[i]) cnt[side_i[i]] = cnt[side_i[i]] + 1'b1;
    end
    for (int i = 0; i < NSLOT; i++)
      mask_o[i] = use_x[i] && (cnt[side_i[i]] > CNT_W'(1));
  end

  always_comb begin
    AST_XP_HALF0: assert ($countones(mask_o & ~side_i) != 1) else $error("lone cross user half 0"); // R2
    AST_XP_HALF1: assert ($countones(mask_o & side_i) != 1) else $error("lone cross user half 1"); // R2
    for (int i = 0; i < NSLOT; i++)
      AST_XP_NOT_D: assert (!(mask_o[i] && unit_e'(unit_i[2*i +: 2]) == UNIT_D)) else $error("D in cross"); // R3
  end
endmodule

// File: rtl/mem_rules.sv
module mem_rules
  import issue_rule_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int REG_W = 5
) (
  input  logic [NSLOT-1:0]       vld_i,
  input  logic [NSLOT-1:0]       side_i,
  input  logic [2*NSLOT-1:0]     unit_i,
  input  logic [2*NSLOT-1:0]     ls_i,
  input  logic [REG_W*NSLOT-1:0] base_i,
  input  logic [REG_W*NSLOT-1:0] data_i,
  output logic [NSLOT-1:0]       base_mask_o,
  output logic [NSLOT-1:0]       pair_mask_o
);
  logic [NSLOT-1:0] is_ld, is_st, data_f;
  logic [1:0]       ld_in_f, st_in_f;

  always_comb begin
    ld_in_f = '0;
    st_in_f = '0;
    for (int i = 0; i < NSLOT; i++) begin
      is_ld[i]  = vld_i[i] && acc_e'(ls_i[2*i +: 2]) == ACC_LOAD;
      is_st[i]  = vld_i[i] && acc_e'(ls_i[2*i +: 2]) == ACC_STORE;
      data_f[i] = data_i[REG_W*i + REG_W-1];
      if (is_ld[i]) ld_in_f[data_f[i]] = 1'b1;
      if (is_st[i]) st_in_f[data_f[i]] = 1'b1;
      base_mask_o[i] = (is_ld[i] || is_st[i]) && unit_e'(unit_i[2*i +: 2]) == UNIT_D &&
                       base_i[REG_W*i + REG_W-1] != side_i[i];
    end
    for (int i = 0; i < NSLOT; i++)
      pair_mask_o[i] = (is_ld[i] || is_st[i]) && ld_in_f[data_f[i]] && st_in_f[data_f[i]];
  end

  always_comb begin
    AST_LDST_PAIR: assert (pair_mask_o == '0 || $countones(pair_mask_o) >= 2) else $error("lone ld/st"); // R5
    for (int i = 0; i < NSLOT; i++)
      AST_BASE_D_ONLY: assert (!(base_mask_o[i] && unit_e'(unit_i[2*i +: 2]) != UNIT_D)) else $error("base on non-D"); // R4
  end
endmodule

// File: rtl/read_limit.sv
module read_limit #(
  parameter int NSLOT  = 8,
  parameter int NSRC   = 2,
  parameter int REG_W  = 5,
  parameter int MAX_RD = 4
) (
  input  logic [NSLOT-1:0]            vld_i,
  input  logic [NSLOT*NSRC-1:0]       src_vld_i,
  input  logic [REG_W*NSLOT*NSRC-1:0] src_reg_i,
  output logic [NSLOT-1:0]            mask_o
);
  localparam int NREG  = 1 << REG_W;
  localparam int NOPS  = NSLOT * NSRC;
  localparam int CNT_W = $clog2(NOPS + 1);

  logic [NOPS-1:0]  live;
  logic [CNT_W-1:0] cnt [NREG];
  logic [NREG-1:0]  over;

  always_comb begin
    for (int o = 0; o < NOPS; o++) live[o] = vld_i[o / NSRC] && src_vld_i[o];
    for (int r = 0; r < NREG; r++) begin
      cnt[r] = '0;
      for (int o = 0; o < NOPS; o++)
        if (live[o] && src_reg_i[REG_W*o +: REG_W] == REG_W'(r)) cnt[r] = cnt[r] + 1'b1;
      over[r] = cnt[r] > CNT_W'(MAX_RD);
    end
    mask_o = '0;
    for (int o = 0; o < NOPS; o++)
      if (live[o] && over[src_reg_i[REG_W*o +: REG_W]]) mask_o[o / NSRC] = 1'b1;
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++)
      AST_READ_SRC: assert (!mask_o[s] || (src_vld_i[NSRC*s +: NSRC] != '0)) else $error("read flag w/o source"); // R6
  end
endmodule

// File: rtl/issue_rule_chk.sv
module issue_rule_chk #(
  parameter  int NSLOT  = 8,
  parameter  int NSRC   = 2,
  parameter  int IDX_W  = 4,
  parameter  int MAX_RD = 4,
  localparam int REG_W  = IDX_W + 1
) (
  input  logic [NSLOT-1:0]            slot_vld_i,
  input  logic [NSLOT-1:0]            slot_side_i,
  input  logic [2*NSLOT-1:0]          slot_unit_i,
  input  logic [NSLOT-1:0]            slot_xpath_i,
  input  logic [2*NSLOT-1:0]          slot_ls_i,
  input  logic [REG_W*NSLOT-1:0]      slot_base_i,
  input  logic [REG_W*NSLOT-1:0]      slot_data_i,
  input  logic [NSLOT*NSRC-1:0]       src_vld_i,
  input  logic [REG_W*NSLOT*NSRC-1:0] src_reg_i,
  output logic [4:0]                  viol_o,
  output logic [NSLOT-1:0]            unit_mask_o,
  output logic [NSLOT-1:0]            xpath_mask_o,
  output logic [NSLOT-1:0]            base_mask_o,
  output logic [NSLOT-1:0]            ldst_mask_o,
  output logic [NSLOT-1:0]            read_mask_o
);
  unit_clash #(.NSLOT(NSLOT)) i_unit_clash (
    .vld_i(slot_vld_i), .side_i(slot_side_i), .unit_i(slot_unit_i), .mask_o(unit_mask_o)
  );

  cross_limit #(.NSLOT(NSLOT)) i_cross_limit (
    .vld_i(slot_vld_i), .side_i(slot_side_i), .unit_i(slot_unit_i),
    .xpath_i(slot_xpath_i), .mask_o(xpath_mask_o)
  );

  mem_rules #(.NSLOT(NSLOT), .REG_W(REG_W)) i_mem_rules (
    .vld_i(slot_vld_i), .side_i(slot_side_i), .unit_i(slot_unit_i), .ls_i(slot_ls_i),
    .base_i(slot_base_i), .data_i(slot_data_i),
    .base_mask_o(base_mask_o), .pair_mask_o(ldst_mask_o)
  );

  read_limit #(.NSLOT(NSLOT), .NSRC(NSRC), .REG_W(REG_W), .MAX_RD(MAX_RD)) i_read_limit (
    .vld_i(slot_vld_i), .src_vld_i(src_vld_i), .src_reg_i(src_reg_i), .mask_o(read_mask_o)
  );

  assign viol_o = {|read_mask_o, |ldst_mask_o, |base_mask_o, |xpath_mask_o, |unit_mask_o};

  always_comb begin
    AST_MASK_VALID: assert (((unit_mask_o | xpath_mask_o | base_mask_o | ldst_mask_o | read_mask_o)
                             & ~slot_vld_i) == '0) else $error("invalid slot flagged"); // R7
  end
endmodule

// File: tb/test_issue_rule_chk.sv
module test_issue_rule_chk;
  localparam int NSLOT = 8;
  localparam int NSRC  = 2;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       vld [NSLOT];
  logic       sd  [NSLOT];
  logic [1:0] un  [NSLOT];
  logic       xp  [NSLOT];
  logic [1:0] ls  [NSLOT];
  logic [4:0] bs  [NSLOT];
  logic [4:0] dt  [NSLOT];
  logic       sv  [NSLOT][NSRC];
  logic [4:0] sr  [NSLOT][NSRC];

  logic [NSLOT-1:0] p_vld, p_sd, p_xp;
  logic [2*NSLOT-1:0] p_un, p_ls;
  logic [REG_W*NSLOT-1:0] p_bs, p_dt;
  logic [NSLOT*NSRC-1:0] p_sv;
  logic [REG_W*NSLOT*NSRC-1:0] p_sr;
  logic [4:0] viol;
  logic [NSLOT-1:0] m_un, m_xp, m_bs, m_ls, m_rd;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      p_vld[i] = vld[i]; p_sd[i] = sd[i]; p_xp[i] = xp[i];
      p_un[2*i +: 2] = un[i]; p_ls[2*i +: 2] = ls[i];
      p_bs[5*i +: 5] = bs[i]; p_dt[5*i +: 5] = dt[i];
      for (int k = 0; k < NSRC; k++) begin
        p_sv[i*NSRC+k] = sv[i][k];
        p_sr[5*(i*NSRC+k) +: 5] = sr[i][k];
      end
    end
  end

  issue_rule_chk i_issue_rule_chk (
    .slot_vld_i(p_vld), .slot_side_i(p_sd), .slot_unit_i(p_un), .slot_xpath_i(p_xp),
    .slot_ls_i(p_ls), .slot_base_i(p_bs), .slot_data_i(p_dt), .src_vld_i(p_sv),
    .src_reg_i(p_sr), .viol_o(viol), .unit_mask_o(m_un), .xpath_mask_o(m_xp),
    .base_mask_o(m_bs), .ldst_mask_o(m_ls), .read_mask_o(m_rd)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference: duplicate units
  function automatic logic [7:0] e_unit();
    logic [7:0] m = '0;
    for (int i = 0; i < NSLOT; i++) begin
      int n = 0;
      for (int j = 0; j < NSLOT; j++)
        if (vld[i] && vld[j] && {sd[i], un[i]} == {sd[j], un[j]}) n++;
      m[i] = (n >= 2);
    end
    return m;
  endfunction

  function automatic logic [7:0] e_cross();
    logic [7:0] m = '0;
    int n [2] = '{0, 0};
    for (int i = 0; i < NSLOT; i++) if (vld[i] && xp[i] && un[i] != 2'd3) n[sd[i]] += 1;
    for (int i = 0; i < NSLOT; i++) m[i] = vld[i] && xp[i] && un[i] != 2'd3 && n[sd[i]] > 1;
    return m;
  endfunction

  function automatic logic [7:0] e_base();
    logic [7:0] m = '0;
    for (int i = 0; i < NSLOT; i++)
      m[i] = vld[i] && un[i] == 2'd3 && (ls[i] == 2'd1 || ls[i] == 2'd2) && bs[i][4] != sd[i];
    return m;
  endfunction

  function automatic logic [7:0] e_ldst();
    logic [7:0] m = '0;
    for (int i = 0; i < NSLOT; i++)
      for (int j = 0; j < NSLOT; j++)
        if (vld[i] && vld[j] && dt[i][4] == dt[j][4] &&
            ((ls[i] == 2'd1 && ls[j] == 2'd2) || (ls[i] == 2'd2 && ls[j] == 2'd1)))
          m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] e_read();
    logic [7:0] m = '0;
    for (int i = 0; i < NSLOT; i++)
      for (int k = 0; k < NSRC; k++) begin
        int n = 0;
        if (vld[i] && sv[i][k]) begin
          for (int j = 0; j < NSLOT; j++)
            for (int q = 0; q < NSRC; q++)
              if (vld[j] && sv[j][q] && sr[j][q] == sr[i][k]) n++;
          if (n > 4) m[i] = 1'b1;
        end
      end
    return m;
  endfunction

  task automatic run(string tag);
    logic [7:0] a, b, c, d, e;
    #2;
    a = e_unit(); b = e_cross(); c = e_base(); d = e_ldst(); e = e_read();
    chk(tag, "unit_mask", m_un, a);
    chk(tag, "xpath_mask", m_xp, b);
    chk(tag, "base_mask", m_bs, c);
    chk(tag, "ldst_mask", m_ls, d);
    chk(tag, "read_mask", m_rd, e);
    chk(tag, "viol", {3'b0, viol}, {3'b0, |e, |d, |c, |b, |a});
  endtask

  task automatic clear();
    for (int i = 0; i < NSLOT; i++) begin
      vld[i] = 0; sd[i] = 0; un[i] = 0; xp[i] = 0; ls[i] = 0; bs[i] = 0; dt[i] = 0;
      for (int k = 0; k < NSRC; k++) begin sv[i][k] = 0; sr[i][k] = 0; end
    end
  endtask

  initial begin
    clear();
    @(negedge clk); run("R7 empty");
    @(negedge clk); #2;
    chk("R7", "empty all zero", {3'b0, viol} | m_un | m_xp | m_bs | m_ls | m_rd, 8'h00);

    // R1: every unit pair over slots 0 and 5
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        @(negedge clk); clear();
        vld[0] = 1; sd[0] = a[2]; un[0] = a[1:0];
        vld[5] = 1; sd[5] = b[2]; un[5] = b[1:0];
        run("R1");
      end

    // R2/R3: three slots, all half/unit/cross combinations
    for (int u = 0; u < 64; u++)
      for (int x = 0; x < 8; x++)
        for (int s = 0; s < 8; s++) begin
          @(negedge clk); clear();
          vld[1] = 1; un[1] = u[1:0]; xp[1] = x[0]; sd[1] = s[0];
          vld[3] = 1; un[3] = u[3:2]; xp[3] = x[1]; sd[3] = s[1];
          vld[6] = 1; un[6] = u[5:4]; xp[6] = x[2]; sd[6] = s[2];
          run((u % 4 == 3) ? "R3" : "R2");
        end

    // R4: base file versus half
    for (int u = 0; u < 4; u++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 4; l++)
          for (int f = 0; f < 2; f++) begin
            @(negedge clk); clear();
            vld[2] = 1; un[2] = 2'(u); sd[2] = s[0]; ls[2] = 2'(l); bs[2] = {f[0], 4'd7};
            run("R4");
          end

    // R5: load/store pairs over data files
    for (int la = 0; la < 4; la++)
      for (int lb = 0; lb < 4; lb++)
        for (int f = 0; f < 4; f++) begin
          @(negedge clk); clear();
          vld[4] = 1; un[4] = 2'd3; ls[4] = 2'(la); dt[4] = {f[0], 4'd3}; bs[4] = 5'h00;
          vld[7] = 1; un[7] = 2'd3; sd[7] = 1; ls[7] = 2'(lb); dt[7] = {f[1], 4'd9}; bs[7] = 5'h10;
          run("R5");
        end

    // R6: n reads of one register, boundary at four
    for (int n = 0; n <= 16; n++)
      for (int r = 0; r < 32; r += 9) begin
        @(negedge clk); clear();
        for (int i = 0; i < NSLOT; i++) begin
          vld[i] = 1; un[i] = 2'(i % 4); sd[i] = i[2];
          for (int k = 0; k < NSRC; k++) begin
            sv[i][k] = (i*NSRC + k) < n;
            sr[i][k] = 5'(r);
          end
        end
        run("R6");
      end
    @(negedge clk); clear();
    for (int i = 0; i < 3; i++) begin
      vld[i] = 1; sv[i][0] = 1; sr[i][0] = 5'h02; sv[i][1] = 1; sr[i][1] = 5'h12;
    end
    run("R6 split files");

    // R7: fully conflicting packet under every valid pattern
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); clear();
      for (int i = 0; i < NSLOT; i++) begin
        vld[i] = v[i]; un[i] = (i < 4) ? 2'd0 : 2'd3; xp[i] = 1; sd[i] = 0;
        ls[i] = (i % 2 == 0) ? 2'd1 : 2'd2; dt[i] = 5'h01; bs[i] = 5'h15;
        sv[i][0] = 1; sr[i][0] = 5'h04;
      end
      run("R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule